// File: doc/BRIEF.md
# Pulse-by-pulse overcurrent fault handler

This block sits between a PWM generator and the power switch driver of a switching regulator. It watches the output of an external current comparator. When that comparator reports an overcurrent inside a pulse, the block ends the pulse at once and keeps the switch off for the rest of the switching cycle. Every such event sets a sticky status flag, which stays set until it is read.

A comparator edge right after the switch turns on is often false. So the block ignores the comparator for a programmable blanking window from the start of each pulse. It also requires the comparator to stay high for a programmable number of clocks before it accepts a trip. Switching cycles that trip one after another are counted. When the count reaches a selectable limit of 1, 2, 4 or 8, the block can escalate to one of two shutdowns. The first holds the output off for a fixed number of cycles and then asks for a soft start. The second holds the output off until the supply-enable input has been seen low and then high again.

Top module: `ocp_pulse_guard`

## Requirements
- R1: In every action setting, a qualified trip drives `pwm_o` low in the same clock. `pwm_o` then stays low until the next `cyc_start_i`.
- R2: After a cut pulse with no escalation, `pwm_o` equals `pwm_req_i` for the whole of the next switching cycle.
- R3: Trips are ignored while the pulse age is below `cfg_blank_i` × BLANK_STEP clocks. The pulse age counts from 0 at the first clock of `pwm_req_i` high. Code 0 means no blanking.
- R4: A trip is accepted only when `cmp_i` is high on an unblanked pulse clock and on the `cfg_deb_i` unblanked pulse clocks just before it. A shorter run of high clocks never cuts the pulse.
- R5: With `cfg_act_i` = 00 or 11 (ignore), no number of tripping cycles raises `shdn_o`. Only the pulse is cut.
- R6: `cfg_n_i` sets the limit n = 1 << code, giving 1, 2, 4 or 8. Only consecutive tripping cycles count, because a cycle with no trip resets the count. Escalation happens at the first trip of the n-th consecutive tripping cycle.
- R7: With `cfg_act_i` = 01, escalation raises `shdn_o` from the next clock. The release comes at the SOFT_HOLD_CYC-th `cyc_start_i` after the escalation. From the clock after that strobe, `shdn_o` is low and `ss_req_o` is high for exactly one clock.
- R8: With `cfg_act_i` = 10, `shdn_o` stays high across cycles until `supply_en_i` has been sampled low and then sampled high. It falls in the clock after the high sample. `ss_req_o` stays low throughout.
- R9: `ocp_flag_o` goes high in the clock after a trip and holds until a clock with `flag_rd_i` high. It falls in the clock after that read. A trip in the same clock as a read leaves the flag set.
- R10: While `shdn_o` is high, `pwm_o` is low and comparator activity sets neither a trip nor the flag.
- R11: During and straight after reset, `ocp_flag_o`, `shdn_o` and `ss_req_o` are low, and `pwm_o` follows `pwm_req_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start_i | input | 1 | One-clock strobe marking the first clock of a switching cycle |
| pwm_req_i | input | 1 | Raw PWM request from the modulator |
| cmp_i | input | 1 | Overcurrent comparator output, high means over the limit |
| supply_en_i | input | 1 | Supply-enable input used to leave the wait-for-enable shutdown |
| flag_rd_i | input | 1 | Status read strobe, clears the overcurrent flag |
| cfg_blank_i | input | 3 | Leading-edge blanking code |
| cfg_deb_i | input | DEB_W | Debounce length in clocks |
| cfg_act_i | input | 2 | Escalation action: 00/11 ignore, 01 soft-start shutdown, 10 wait-for-enable shutdown |
| cfg_n_i | input | 2 | Tripping-cycle limit code, n = 1 << code |
| pwm_o | output | 1 | Gated PWM to the switch driver |
| ocp_flag_o | output | 1 | Sticky overcurrent status flag |
| shdn_o | output | 1 | Shutdown in force |
| ss_req_o | output | 1 | One-clock soft-start request at release from soft-start shutdown |

## Verification
The bench uses the default parameters: BLANK_STEP = 4, DEB_W = 4 and SOFT_HOLD_CYC = 2. With a step of 4, blanking codes 1 to 4 fall inside a 20-clock test pulse, and code 7 (28 clocks) blanks the whole pulse. A 4-bit debounce lets the largest setting, 15 clocks, be reached inside one pulse. The two-cycle hold lets the soft-start release and its one-clock request be seen within two switching cycles after the escalation. The limit of eight consecutive tripping cycles is driven in full.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        ACT_IGNORE     = 2'b00,
        ACT_SOFTSTART  = 2'b01,
        ACT_WAITEN     = 2'b10,
        ACT_IGNORE_ALT = 2'b11
    } ocp_act_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_HOLD = 2'b01,
        ST_WAIT = 2'b10
    } esc_state_e;

    localparam int CNT_W = 4;

    function automatic logic [CNT_W-1:0] trip_limit(input logic [1:0] code);
        return CNT_W'(1) << code;
    endfunction

endpackage

// File: rtl/ocp_qualify.sv
module ocp_qualify #(
    parameter int BLANK_STEP = 4,
    parameter int DEB_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_i,
    input  logic             cmp_i,
    input  logic [2:0]       blank_code_i,
    input  logic [DEB_W-1:0] deb_i,
    output logic             trip_o
);
    localparam int BLANK_MAX = 7 * BLANK_STEP;
    localparam int AGE_W     = $clog2(BLANK_MAX + 1);

    typedef struct packed {
        logic [AGE_W-1:0] age;
        logic [DEB_W-1:0] deb;
    } qual_s;

    qual_s s_d, s_q;
    logic [AGE_W-1:0] blank_len;
    logic             blanked;
    logic             armed;

    always_comb begin
        s_d       = s_q;
        blank_len = AGE_W'(blank_code_i) * AGE_W'(BLANK_STEP);
        blanked   = s_q.age < blank_len;
        armed     = pulse_i && !blanked && cmp_i;
        trip_o    = armed && (s_q.deb >= deb_i);

        // pulse age saturates once beyond the longest blanking window
        if (!pulse_i) begin
            s_d.age = '0;
        end else if (s_q.age != AGE_W'(BLANK_MAX)) begin
            s_d.age = s_q.age + 1'b1;
        end

        // consecutive unblanked high clocks before the current one
        if (!armed) begin
            s_d.deb = '0;
        end else if (!(&s_q.deb)) begin
            s_d.deb = s_q.deb + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ocp_escalate.sv
module ocp_escalate
    import ocp_pkg::*;
#(
    parameter int SOFT_HOLD_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_start_i,
    input  logic       trip_i,
    input  logic       supply_en_i,
    input  logic [1:0] act_i,
    input  logic [1:0] n_code_i,
    output logic       hit_o,
    output logic       shdn_o,
    output logic       ss_req_o
);
    localparam int HOLD_W = $clog2(SOFT_HOLD_CYC + 1);

    typedef struct packed {
        esc_state_e        state;
        logic              hit;
        logic [CNT_W-1:0]  cnt;
        logic [HOLD_W-1:0] hold;
        logic              seen_low;
        logic              ss;
    } esc_s;

    esc_s s_d, s_q;
    logic             trip_run;
    logic             first_trip;
    logic             escalate;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        s_d      = s_q;
        s_d.ss   = 1'b0;
        trip_run = trip_i && (s_q.state == ST_RUN);

        // a cycle start closes the previous cycle: a clean one clears the run
        if (cyc_start_i) begin
            base       = s_q.hit ? s_q.cnt : '0;
            first_trip = trip_run;
            s_d.hit    = trip_run;
        end else begin
            base       = s_q.cnt;
            first_trip = trip_run && !s_q.hit;
            s_d.hit    = s_q.hit || trip_run;
        end

        if (first_trip && !(&base)) begin
            cnt_next = base + 1'b1;
        end else begin
            cnt_next = base;
        end
        s_d.cnt  = cnt_next;

        escalate = first_trip && (cnt_next >= trip_limit(n_code_i)) &&
                   ((act_i == ACT_SOFTSTART) || (act_i == ACT_WAITEN));

        unique case (s_q.state)
            ST_RUN: begin
                if (escalate) begin
                    s_d.cnt      = '0;
                    s_d.hit      = 1'b0;
                    s_d.hold     = '0;
                    s_d.seen_low = 1'b0;
                    s_d.state    = (act_i == ACT_SOFTSTART) ? ST_HOLD : ST_WAIT;
                end
            end
            ST_HOLD: begin
                if (cyc_start_i) begin
                    if (s_q.hold == HOLD_W'(SOFT_HOLD_CYC - 1)) begin
                        s_d.state = ST_RUN;
                        s_d.hold  = '0;
                        s_d.ss    = 1'b1;
                    end else begin
                        s_d.hold = s_q.hold + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (!supply_en_i) begin
                    s_d.seen_low = 1'b1;
                end else if (s_q.seen_low) begin
                    s_d.state    = ST_RUN;
                    s_d.seen_low = 1'b0;
                end
            end
            default: s_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hit_o    = s_q.hit;
    assign shdn_o   = (s_q.state != ST_RUN);
    assign ss_req_o = s_q.ss;

endmodule

// File: rtl/ocp_flag.sv
module ocp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic rd_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (trip_i) begin
            flag_d = 1'b1;
        end else if (rd_i) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/ocp_pulse_guard.sv
module ocp_pulse_guard #(
    parameter int BLANK_STEP    = 4,
    parameter int DEB_W         = 4,
    parameter int SOFT_HOLD_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start_i,
    input  logic             pwm_req_i,
    input  logic             cmp_i,
    input  logic             supply_en_i,
    input  logic             flag_rd_i,
    input  logic [2:0]       cfg_blank_i,
    input  logic [DEB_W-1:0] cfg_deb_i,
    input  logic [1:0]       cfg_act_i,
    input  logic [1:0]       cfg_n_i,
    output logic             pwm_o,
    output logic             ocp_flag_o,
    output logic             shdn_o,
    output logic             ss_req_o
);
    logic pulse_live;
    logic trip_hit;
    logic cycle_cut;

    assign pulse_live = pwm_req_i && !shdn_o;

    ocp_qualify #(
        .BLANK_STEP (BLANK_STEP),
        .DEB_W      (DEB_W)
    ) u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .pulse_i      (pulse_live),
        .cmp_i        (cmp_i),
        .blank_code_i (cfg_blank_i),
        .deb_i        (cfg_deb_i),
        .trip_o       (trip_hit)
    );

    ocp_escalate #(
        .SOFT_HOLD_CYC (SOFT_HOLD_CYC)
    ) u_esc (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_start_i (cyc_start_i),
        .trip_i      (trip_hit),
        .supply_en_i (supply_en_i),
        .act_i       (cfg_act_i),
        .n_code_i    (cfg_n_i),
        .hit_o       (cycle_cut),
        .shdn_o      (shdn_o),
        .ss_req_o    (ss_req_o)
    );

    ocp_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .trip_i (trip_hit),
        .rd_i   (flag_rd_i),
        .flag_o (ocp_flag_o)
    );

    // the cut of the previous cycle no longer applies on the new cycle's first clock
    assign pwm_o = pulse_live && !(cycle_cut && !cyc_start_i) && !trip_hit;

endmodule

// File: rtl/ocp_pulse_guard_chk.sv
module ocp_pulse_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_start_i,
    input logic pwm_req_i,
    input logic flag_rd_i,
    input logic pwm_o,
    input logic ocp_flag_o,
    input logic shdn_o,
    input logic ss_req_o,
    input logic trip_hit
);
    // R1: once cut outside shutdown, the output stays low until a new cycle starts
    p_cut_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_req_i && !pwm_o && !shdn_o) |=> (cyc_start_i || !pwm_o))
        else $error("p_cut_holds_r1");

    // R9: a trip sets the flag on the next clock
    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trip_hit |=> ocp_flag_o)
        else $error("p_flag_set_r9");

    // R9: a read with no trip clears the flag
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ocp_flag_o && flag_rd_i && !trip_hit) |=> !ocp_flag_o)
        else $error("p_flag_clear_r9");

    // R7: the soft-start request lasts one clock
    p_ss_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ss_req_o |=> !ss_req_o)
        else $error("p_ss_single_r7");

    // R7: the request comes with the release
    p_ss_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ss_req_o |-> !shdn_o)
        else $error("p_ss_released_r7");

    // R10: shutdown blocks the output and any new trip
    p_shdn_gates_r10: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_o |-> (!pwm_o && !trip_hit))
        else $error("p_shdn_gates_r10");

endmodule

bind ocp_pulse_guard ocp_pulse_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start_i (cyc_start_i),
    .pwm_req_i   (pwm_req_i),
    .flag_rd_i   (flag_rd_i),
    .pwm_o       (pwm_o),
    .ocp_flag_o  (ocp_flag_o),
    .shdn_o      (shdn_o),
    .ss_req_o    (ss_req_o),
    .trip_hit    (trip_hit)
);

// File: tb/tb_ocp_pulse_guard.sv
module tb_ocp_pulse_guard;

    localparam int BLANK_STEP    = 4;
    localparam int DEB_W         = 4;
    localparam int SOFT_HOLD_CYC = 2;
    localparam int PULSE_LEN     = 20;
    localparam int CYC_LEN       = 24;
    localparam int NONE          = 255;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cyc_start_i = 1'b0;
    logic             pwm_req_i = 1'b0;
    logic             cmp_i = 1'b0;
    logic             supply_en_i = 1'b1;
    logic             flag_rd_i = 1'b0;
    logic [2:0]       cfg_blank_i = 3'd0;
    logic [DEB_W-1:0] cfg_deb_i = '0;
    logic [1:0]       cfg_act_i = 2'b00;
    logic [1:0]       cfg_n_i = 2'b00;
    logic             pwm_o;
    logic             ocp_flag_o;
    logic             shdn_o;
    logic             ss_req_o;

    ocp_pulse_guard #(
        .BLANK_STEP    (BLANK_STEP),
        .DEB_W         (DEB_W),
        .SOFT_HOLD_CYC (SOFT_HOLD_CYC)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_start_i (cyc_start_i),
        .pwm_req_i   (pwm_req_i),
        .cmp_i       (cmp_i),
        .supply_en_i (supply_en_i),
        .flag_rd_i   (flag_rd_i),
        .cfg_blank_i (cfg_blank_i),
        .cfg_deb_i   (cfg_deb_i),
        .cfg_act_i   (cfg_act_i),
        .cfg_n_i     (cfg_n_i),
        .pwm_o       (pwm_o),
        .ocp_flag_o  (ocp_flag_o),
        .shdn_o      (shdn_o),
        .ss_req_o    (ss_req_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // results of one switching cycle
    int first_cut, hi_after, pwm_hi, ss_k, ss_cnt, shdn_end, flag_end;

    typedef struct packed {
        logic [2:0] blank;
        logic [3:0] deb;
        logic [7:0] at;
        logic [7:0] len;
        logic [7:0] cut;
    } vec_t;

    // blank code, debounce, comparator start (pulse clock), run length, expected cut clock
    localparam vec_t VECS [9] = '{
        '{3'd0, 4'd0,  8'd5,  8'd1,  8'd5},
        '{3'd1, 4'd0,  8'd2,  8'd4,  8'd4},
        '{3'd2, 4'd0,  8'd2,  8'd4,  8'd255},
        '{3'd0, 4'd3,  8'd3,  8'd3,  8'd255},
        '{3'd0, 4'd3,  8'd3,  8'd4,  8'd6},
        '{3'd3, 4'd2,  8'd10, 8'd6,  8'd14},
        '{3'd7, 4'd0,  8'd0,  8'd20, 8'd255},
        '{3'd0, 4'd15, 8'd0,  8'd20, 8'd15},
        '{3'd4, 4'd1,  8'd15, 8'd5,  8'd17}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one switching cycle: strobe at k=0, pulse on clocks k=1..PULSE_LEN
    task automatic run_cycle(input int t_at, input int t_len, input int rd_k);
        first_cut = NONE; hi_after = 0; pwm_hi = 0; ss_k = NONE; ss_cnt = 0;
        for (int k = 0; k < CYC_LEN; k++) begin
            int p;
            @(posedge clk); #1;
            p = k - 1;
            cyc_start_i = (k == 0);
            pwm_req_i   = (p >= 0) && (p < PULSE_LEN);
            cmp_i       = pwm_req_i && (p >= t_at) && (p < t_at + t_len);
            flag_rd_i   = (k == rd_k);
            #5;
            if (pwm_req_i) begin
                if (pwm_o) begin
                    pwm_hi++;
                    if (first_cut != NONE) hi_after++;
                end else if (first_cut == NONE) begin
                    first_cut = p;
                end
            end
            if (ss_req_o) begin
                ss_cnt++;
                if (ss_k == NONE) ss_k = k;
            end
        end
        shdn_end = int'(shdn_o);
        flag_end = int'(ocp_flag_o);
    endtask

    task automatic enable_toggle();
        @(posedge clk); #1 supply_en_i = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1 supply_en_i = 1'b1;
        #5 check("R8", "shdn before high sampled", int'(shdn_o), 1);
        @(posedge clk); #6;
        check("R8", "shdn after enable toggle", int'(shdn_o), 0);
        check("R8", "no soft-start request", int'(ss_req_o), 0);
    endtask

    initial begin
        // reset state
        pwm_req_i = 1'b1;
        repeat (3) @(posedge clk);
        #6;
        check("R11", "flag in reset", int'(ocp_flag_o), 0);
        check("R11", "shdn in reset", int'(shdn_o), 0);
        check("R11", "ss in reset", int'(ss_req_o), 0);
        check("R11", "pwm in reset", int'(pwm_o), 1);
        @(posedge clk); #1 rst_n = 1'b1;
        @(posedge clk); #5;
        check("R11", "pwm after reset", int'(pwm_o), 1);
        check("R11", "flag after reset", int'(ocp_flag_o), 0);
        #1 pwm_req_i = 1'b0;

        // table walk in ignore mode with n=1
        cfg_act_i = 2'b00;
        cfg_n_i   = 2'b00;
        foreach (VECS[i]) begin
            cfg_blank_i = VECS[i].blank;
            cfg_deb_i   = VECS[i].deb;
            run_cycle(int'(VECS[i].at), int'(VECS[i].len), 0);
            check("R3 R4", $sformatf("cut clock vec %0d", i), first_cut, int'(VECS[i].cut));
            check("R1", $sformatf("stays low vec %0d", i), hi_after, 0);
            check("R5", $sformatf("no shutdown vec %0d", i), shdn_end, 0);
            check("R9", $sformatf("flag vec %0d", i), flag_end, (VECS[i].cut != 8'd255) ? 1 : 0);
            run_cycle(NONE, 0, -1);
            check("R2", $sformatf("next cycle normal vec %0d", i), pwm_hi, PULSE_LEN);
        end

        // flag: set wins over read, held, then cleared
        cfg_blank_i = 3'd0;
        cfg_deb_i   = '0;
        run_cycle(NONE, 0, 0);
        run_cycle(5, 1, 6);
        check("R9", "set wins over read", flag_end, 1);
        run_cycle(NONE, 0, -1);
        check("R9", "flag held", flag_end, 1);
        run_cycle(NONE, 0, 3);
        check("R9", "flag cleared by read", flag_end, 0);

        // soft-start shutdown, n=2, consecutive count
        cfg_act_i = 2'b01;
        cfg_n_i   = 2'b01;
        run_cycle(5, 1, -1);
        check("R6", "first trip no shutdown", shdn_end, 0);
        run_cycle(NONE, 0, -1);
        run_cycle(5, 1, -1);
        check("R6", "clean cycle resets count", shdn_end, 0);
        run_cycle(5, 1, -1);
        check("R6", "second consecutive escalates", shdn_end, 1);
        check("R1", "cut at escalation", first_cut, 5);
        run_cycle(3, 10, 0);
        check("R10", "pwm off in shutdown", pwm_hi, 0);
        check("R10", "no flag in shutdown", flag_end, 0);
        check("R7", "hold across first strobe", shdn_end, 1);
        check("R7", "no early request", ss_cnt, 0);
        run_cycle(NONE, 0, -1);
        check("R7", "request clock", ss_k, 1);
        check("R7", "request width", ss_cnt, 1);
        check("R7", "pwm after release", pwm_hi, PULSE_LEN);
        check("R7", "released", shdn_end, 0);

        // wait-for-enable shutdown, n=1
        cfg_act_i = 2'b10;
        cfg_n_i   = 2'b00;
        run_cycle(5, 1, -1);
        check("R8", "escalates at n=1", shdn_end, 1);
        run_cycle(NONE, 0, -1);
        check("R8", "held while enable high", shdn_end, 1);
        check("R8", "pwm off while held", pwm_hi, 0);
        enable_toggle();
        run_cycle(NONE, 0, -1);
        check("R8", "pwm after release", pwm_hi, PULSE_LEN);
        check("R8", "no request on release", ss_cnt, 0);

        // n=8
        cfg_n_i = 2'b11;
        for (int c = 0; c < 7; c++) run_cycle(5, 1, -1);
        check("R6", "seven trips no shutdown", shdn_end, 0);
        run_cycle(5, 1, -1);
        check("R6", "eighth trip escalates", shdn_end, 1);
        enable_toggle();

        // alternate ignore code
        cfg_act_i = 2'b11;
        cfg_n_i   = 2'b00;
        run_cycle(5, 1, -1);
        check("R5", "code 11 cut", first_cut, 5);
        check("R5", "code 11 no shutdown", shdn_end, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule